// File: doc/BRIEF.md
# Calibration Sequencer with Ready Timing

This block controls the timing of an analog front end's calibration passes. A 2-bit calibration command is written to it. Command 01 runs an internal zero-scale step and then an internal full-scale step. Command 10 runs one zero-scale step on the analog input. Command 11 runs one full-scale step on the analog input. Command 00 means normal operation and starts nothing. Each step lasts a fixed number of output-data periods. The output-rate tick input marks those periods.

Completion is reported in two ways, with different latencies:

- **Mode readback.** The readback returns to 00 as soon as the calibration steps finish.
- **Data-ready.** The active-low data-ready output stays high until one more normal conversion has run and a pipeline delay, counted in master-clock cycles, has passed. When data-ready falls, the result register holds a valid new sample.

While a sequence runs, the block ignores new commands and refuses requests to write the coefficient registers. The block does no conversion arithmetic.

Top module: `cal_sequencer`

## Requirements
- R1: When reset is asserted, the outputs go at once to: mode readback 00, `drdy_n` high, `cal_busy` low, and all step flags low. They stay there until the synchronised reset release.
- R2: Command 01 sets `zs_step` for the first 3 ticks after acceptance and `fs_step` for the next 3 ticks. `sys_src` stays low. The readback shows 01 until the 6th tick and 00 from the clock edge of that tick onward.
- R3: Command 10 sets `zs_step` and `sys_src` for 3 ticks. Command 11 sets `fs_step` and `sys_src` for 3 ticks. In both cases the readback returns to 00 on the 3rd tick.
- R4: `drdy_n` goes high on the clock edge that accepts a command. It falls exactly `PIPE_CLKS` clock cycles after the edge of the 9th tick (command 01) or the 4th tick (commands 10 and 11).
- R5: `cal_busy` is high from the accepting edge until the edge on which `drdy_n` falls. It falls on that same edge.
- R6: A command write while `cal_busy` is high has no effect on the readback, the steps or the timing.
- R7: `coef_wr_grant` equals `coef_wr_req` when `cal_busy` is low, and is 0 otherwise.
- R8: Writing command 00 while idle starts no sequence and leaves `drdy_n` unchanged.
- R9: A tick in the same cycle as the command's acceptance is not counted toward any step.
- R10: `PIPE_CLKS` lies between 1 and 2000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised internally |
| rate_tick | input | 1 | One-cycle pulse at each output-data period |
| mode_wr | input | 1 | Command write strobe |
| mode_wdata | input | 2 | Command value (00 normal, 01 internal pair, 10 system zero, 11 system full) |
| coef_wr_req | input | 1 | Request to write the coefficient registers |
| mode_rb | output | 2 | Command readback; 00 once the calibration steps are done |
| drdy_n | output | 1 | Active-low data-ready |
| cal_busy | output | 1 | A sequence is in progress |
| zs_step | output | 1 | A zero-scale step is active |
| fs_step | output | 1 | A full-scale step is active |
| sys_src | output | 1 | The active step measures the analog input rather than internal references |
| coef_wr_grant | output | 1 | The coefficient write request is accepted |

## Verification
The assertions check, on every cycle, the relationships between the outputs:

- data-ready stays high while busy;
- busy and data-ready fall on the same edge;
- the two step flags are never both set;
- a nonzero readback never changes to another nonzero value;
- busy rises only after a nonzero command write;
- a granted coefficient write never overlaps a sequence.

The exact tick counts for each command, the clock-accurate pipeline delay, the rejection of commands during both the calibration and pipeline phases, and the handling of a tick that coincides with the command can only be shown by the bench's scenarios. The bench compares every cycle of each scenario against its own tick and clock counts.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_STEP_A = 3'd1,
    PH_STEP_B = 3'd2,
    PH_CONV   = 3'd3,
    PH_PIPE   = 3'd4
  } phase_t;

  typedef enum logic [1:0] {
    MD_NORMAL   = 2'b00,
    MD_SELF     = 2'b01,
    MD_SYS_ZERO = 2'b10,
    MD_SYS_FULL = 2'b11
  } cal_mode_t;

endpackage

// File: rtl/cal_rst_sync.sv
module cal_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/cal_tick_ctr.sv
module cal_tick_ctr #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         hit
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    hit    = tick && !clr && (cnt_q == limit - W'(1));
    cnt_en = clr || tick;
    if (clr || hit) cnt_d = '0;
    else            cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/cal_pipe_tmr.sv
module cal_pipe_tmr #(
  parameter int PIPE_CLKS = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);

  localparam int PW = $clog2(PIPE_CLKS + 1);

  logic [PW-1:0] cnt_q;
  logic [PW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    done   = run && (cnt_q == PW'(PIPE_CLKS - 1));
    cnt_en = run || (cnt_q != '0);
    if (!run || done) cnt_d = '0;
    else              cnt_d = cnt_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/cal_seq_ctrl.sv
module cal_seq_ctrl
  import cal_seq_pkg::*;
#(
  parameter int SELF_ZS_TICKS   = 3,
  parameter int SELF_FS_TICKS   = 3,
  parameter int SELF_CONV_TICKS = 3,
  parameter int SYS_TICKS       = 3,
  parameter int SYS_CONV_TICKS  = 1,
  parameter int TW              = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_wr,
  input  logic [1:0]    mode_wdata,
  input  logic          tick_hit,
  input  logic          pipe_done,
  output logic          tick_clr,
  output logic [TW-1:0] tick_limit,
  output logic          pipe_run,
  output logic [1:0]    mode_rb,
  output logic          drdy_n,
  output logic          cal_busy,
  output logic          zs_step,
  output logic          fs_step,
  output logic          sys_src
);

  phase_t    ph_q, ph_d;
  cal_mode_t mode_q, mode_d;
  logic      self_q, self_d;
  logic      drdy_q, drdy_d;
  logic      upd_en;

  // next-state
  always_comb begin
    ph_d     = ph_q;
    mode_d   = mode_q;
    self_d   = self_q;
    drdy_d   = drdy_q;
    tick_clr = 1'b0;
    case (ph_q)
      PH_IDLE: begin
        tick_clr = 1'b1;
        if (mode_wr && (mode_wdata != MD_NORMAL)) begin
          ph_d   = PH_STEP_A;
          mode_d = cal_mode_t'(mode_wdata);
          self_d = (mode_wdata == MD_SELF);
          drdy_d = 1'b1;
        end
      end
      PH_STEP_A: begin
        if (tick_hit) begin
          if (self_q) begin
            ph_d = PH_STEP_B;
          end else begin
            ph_d   = PH_CONV;
            mode_d = MD_NORMAL;
          end
        end
      end
      PH_STEP_B: begin
        if (tick_hit) begin
          ph_d   = PH_CONV;
          mode_d = MD_NORMAL;
        end
      end
      PH_CONV: begin
        if (tick_hit) ph_d = PH_PIPE;
      end
      PH_PIPE: begin
        tick_clr = 1'b1;
        if (pipe_done) begin
          ph_d   = PH_IDLE;
          drdy_d = 1'b0;
        end
      end
      default: begin
        ph_d     = PH_IDLE;
        mode_d   = MD_NORMAL;
        tick_clr = 1'b1;
      end
    endcase
    upd_en = (ph_d != ph_q);
  end

  // tick budget for the phase in progress
  always_comb begin
    case (ph_q)
      PH_STEP_A: tick_limit = self_q ? TW'(SELF_ZS_TICKS) : TW'(SYS_TICKS);
      PH_STEP_B: tick_limit = TW'(SELF_FS_TICKS);
      PH_CONV:   tick_limit = self_q ? TW'(SELF_CONV_TICKS) : TW'(SYS_CONV_TICKS);
      default:   tick_limit = TW'(1);
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      mode_q <= MD_NORMAL;
      self_q <= 1'b0;
      drdy_q <= 1'b1;
    end else if (upd_en) begin
      ph_q   <= ph_d;
      mode_q <= mode_d;
      self_q <= self_d;
      drdy_q <= drdy_d;
    end
  end

  always_comb begin
    pipe_run = (ph_q == PH_PIPE);
    cal_busy = (ph_q != PH_IDLE);
    mode_rb  = mode_q;
    drdy_n   = drdy_q;
    zs_step  = (ph_q == PH_STEP_A) && (mode_q != MD_SYS_FULL);
    fs_step  = (ph_q == PH_STEP_B) ||
               ((ph_q == PH_STEP_A) && (mode_q == MD_SYS_FULL));
    sys_src  = (ph_q == PH_STEP_A) && !self_q;
  end

endmodule

// File: rtl/cal_sequencer.sv
module cal_sequencer
  import cal_seq_pkg::*;
#(
  parameter int SELF_ZS_TICKS   = 3,
  parameter int SELF_FS_TICKS   = 3,
  parameter int SELF_CONV_TICKS = 3,
  parameter int SYS_TICKS       = 3,
  parameter int SYS_CONV_TICKS  = 1,
  parameter int PIPE_CLKS       = 40,
  parameter int RST_STAGES      = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rate_tick,
  input  logic       mode_wr,
  input  logic [1:0] mode_wdata,
  input  logic       coef_wr_req,
  output logic [1:0] mode_rb,
  output logic       drdy_n,
  output logic       cal_busy,
  output logic       zs_step,
  output logic       fs_step,
  output logic       sys_src,
  output logic       coef_wr_grant
);

  localparam int TW = $clog2(SELF_ZS_TICKS + SELF_FS_TICKS + SELF_CONV_TICKS +
                             SYS_TICKS + SYS_CONV_TICKS + 1);

  logic          rst_sync_n;
  logic          tick_clr;
  logic          tick_hit;
  logic [TW-1:0] tick_limit;
  logic          pipe_run;
  logic          pipe_done;

  cal_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cal_tick_ctr #(.W(TW)) u_tick (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (tick_clr),
    .tick  (rate_tick),
    .limit (tick_limit),
    .hit   (tick_hit)
  );

  cal_pipe_tmr #(.PIPE_CLKS(PIPE_CLKS)) u_pipe (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run   (pipe_run),
    .done  (pipe_done)
  );

  cal_seq_ctrl #(
    .SELF_ZS_TICKS   (SELF_ZS_TICKS),
    .SELF_FS_TICKS   (SELF_FS_TICKS),
    .SELF_CONV_TICKS (SELF_CONV_TICKS),
    .SYS_TICKS       (SYS_TICKS),
    .SYS_CONV_TICKS  (SYS_CONV_TICKS),
    .TW              (TW)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .mode_wr    (mode_wr),
    .mode_wdata (mode_wdata),
    .tick_hit   (tick_hit),
    .pipe_done  (pipe_done),
    .tick_clr   (tick_clr),
    .tick_limit (tick_limit),
    .pipe_run   (pipe_run),
    .mode_rb    (mode_rb),
    .drdy_n     (drdy_n),
    .cal_busy   (cal_busy),
    .zs_step    (zs_step),
    .fs_step    (fs_step),
    .sys_src    (sys_src)
  );

  assign coef_wr_grant = coef_wr_req && !cal_busy;

endmodule

// File: rtl/cal_sequencer_chk.sv
module cal_sequencer_chk #(
  parameter int PIPE_CLKS = 40
) (
  input logic       clk,
  input logic       rst_n,
  input logic       mode_wr,
  input logic [1:0] mode_wdata,
  input logic       coef_wr_req,
  input logic [1:0] mode_rb,
  input logic       drdy_n,
  input logic       cal_busy,
  input logic       zs_step,
  input logic       fs_step,
  input logic       sys_src,
  input logic       coef_wr_grant
);

  initial begin
    AST_PIPE_BOUND: assert (PIPE_CLKS >= 1 && PIPE_CLKS <= 2000); // R10
  end

  AST_DRDY_HIGH_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) cal_busy |-> drdy_n); // R4
  AST_BUSY_ENDS_WITH_DRDY: assert property (@(posedge clk) disable iff (!rst_n) $fell(drdy_n) |-> $fell(cal_busy)); // R5
  AST_STEPS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(zs_step && fs_step)); // R2
  AST_STEP_SHOWS_MODE: assert property (@(posedge clk) disable iff (!rst_n) (zs_step || fs_step) |-> (mode_rb != 2'b00)); // R2
  AST_SYS_NEEDS_STEP: assert property (@(posedge clk) disable iff (!rst_n) sys_src |-> (zs_step || fs_step)); // R3
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n) ((mode_rb != 2'b00) && ($past(mode_rb) != 2'b00)) |-> (mode_rb == $past(mode_rb))); // R6
  AST_START_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n) $rose(cal_busy) |-> ($past(mode_wr) && ($past(mode_wdata) != 2'b00))); // R8
  AST_NO_GRANT_IN_SEQ: assert property (@(posedge clk) disable iff (!rst_n) (coef_wr_grant && coef_wr_req) |=> (!cal_busy || !$past(cal_busy) || !coef_wr_grant)); // R7

endmodule

bind cal_sequencer cal_sequencer_chk #(.PIPE_CLKS(PIPE_CLKS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mode_wr       (mode_wr),
  .mode_wdata    (mode_wdata),
  .coef_wr_req   (coef_wr_req),
  .mode_rb       (mode_rb),
  .drdy_n        (drdy_n),
  .cal_busy      (cal_busy),
  .zs_step       (zs_step),
  .fs_step       (fs_step),
  .sys_src       (sys_src),
  .coef_wr_grant (coef_wr_grant)
);

// File: tb/sim_cal_sequencer.sv
module sim_cal_sequencer;

  localparam int CLK_PERIOD = 10;
  localparam int PIPE       = 40;
  localparam int TDIV       = 5;
  localparam int NVEC       = 4;
  localparam logic [1:0] V_MODE [NVEC] = '{2'b01, 2'b10, 2'b11, 2'b00};
  localparam int         V_CAL  [NVEC] = '{6, 3, 3, 0};
  localparam int         V_RDY  [NVEC] = '{9, 4, 4, 0};

  logic       clk;
  logic       rst_n;
  logic       rate_tick;
  logic       mode_wr;
  logic [1:0] mode_wdata;
  logic       coef_wr_req;
  logic [1:0] mode_rb;
  logic       drdy_n;
  logic       cal_busy;
  logic       zs_step;
  logic       fs_step;
  logic       sys_src;
  logic       coef_wr_grant;

  int checks = 0;
  int fails  = 0;

  cal_sequencer #(.PIPE_CLKS(PIPE)) u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .rate_tick     (rate_tick),
    .mode_wr       (mode_wr),
    .mode_wdata    (mode_wdata),
    .coef_wr_req   (coef_wr_req),
    .mode_rb       (mode_rb),
    .drdy_n        (drdy_n),
    .cal_busy      (cal_busy),
    .zs_step       (zs_step),
    .fs_step       (fs_step),
    .sys_src       (sys_src),
    .coef_wr_grant (coef_wr_grant)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Walks one command through every cycle, comparing against counts of ticks and clocks.
  task automatic run_seq(input logic [1:0] m, input int calp, input int rdyp,
                         input bit tick_on_wr, input bit poke, input string tag);
    int ticks = 0;
    int after = -1;
    logic d0;
    int e_mode, e_drdy, e_busy, e_zs, e_fs, e_sys;
    int bm = 0, bd = 0, bb = 0, bs = 0, bg = 0;
    int am = 0, xm = 0, ad = 0, xd = 0, ab = 0, xb = 0, as_ = 0, xs = 0, ag = 0, xg = 0;
    @(negedge clk);
    d0 = drdy_n;
    mode_wr = 1'b1; mode_wdata = m; rate_tick = tick_on_wr; coef_wr_req = 1'b1;
    @(negedge clk);
    for (int cyc = 0; cyc < 400; cyc++) begin
      bit pipe_over;
      pipe_over = (after >= PIPE);
      if (m == 2'b00) begin
        e_mode = 0; e_busy = 0; e_drdy = d0; e_zs = 0; e_fs = 0; e_sys = 0;
      end else begin
        e_mode = (ticks < calp) ? m : 0;
        e_busy = pipe_over ? 0 : 1;
        e_drdy = pipe_over ? 0 : 1;
        if (m == 2'b01) begin
          e_zs = (ticks < 3) ? 1 : 0;
          e_fs = (ticks >= 3 && ticks < 6) ? 1 : 0;
          e_sys = 0;
        end else begin
          e_zs  = (m == 2'b10 && ticks < 3) ? 1 : 0;
          e_fs  = (m == 2'b11 && ticks < 3) ? 1 : 0;
          e_sys = (ticks < 3) ? 1 : 0;
        end
      end
      if (int'(mode_rb) != e_mode && bm == 0) begin bm = 1; am = mode_rb; xm = e_mode; end
      if (int'(drdy_n) != e_drdy && bd == 0) begin bd = 1; ad = drdy_n; xd = e_drdy; end
      if (int'(cal_busy) != e_busy && bb == 0) begin bb = 1; ab = cal_busy; xb = e_busy; end
      if ((int'(zs_step) != e_zs || int'(fs_step) != e_fs || int'(sys_src) != e_sys) && bs == 0) begin
        bs = 1; as_ = {zs_step, fs_step, sys_src}; xs = e_zs*4 + e_fs*2 + e_sys;
      end
      if (int'(coef_wr_grant) != (1 - e_busy) && bg == 0) begin bg = 1; ag = coef_wr_grant; xg = 1 - e_busy; end
      if (m != 2'b00 && after >= PIPE + 3) break;
      if (m == 2'b00 && cyc >= 40) break;
      rate_tick  = ((cyc % TDIV) == TDIV - 1);
      mode_wr    = 1'b0;
      if (poke && (cyc == TDIV + 2 || after == 1)) begin
        mode_wr    = 1'b1;
        mode_wdata = (cyc == TDIV + 2) ? 2'b10 : 2'b01;
      end
      @(posedge clk);
      if (after >= 0) after++;
      if (rate_tick) begin
        ticks++;
        if (ticks == rdyp) after = 0;
      end
      @(negedge clk);
    end
    rate_tick = 1'b0; mode_wr = 1'b0;
    chk(bm == 0, {tag, " readback"}, am, xm);
    chk(bd == 0, {tag, " R4 drdy_n"}, ad, xd);
    chk(bb == 0, {tag, " R5 cal_busy"}, ab, xb);
    chk(bs == 0, {tag, " steps zs/fs/sys"}, as_, xs);
    chk(bg == 0, {tag, " R7 grant"}, ag, xg);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    rst_n = 1'b0; rate_tick = 1'b0; mode_wr = 1'b0; mode_wdata = 2'b00; coef_wr_req = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(mode_rb == 2'b00, "R1 readback in reset", mode_rb, 0);
    chk(drdy_n == 1'b1, "R1 drdy_n in reset", drdy_n, 1);
    chk(cal_busy == 1'b0, "R1 busy in reset", cal_busy, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    coef_wr_req = 1'b1;
    #1;
    chk(coef_wr_grant == 1'b1, "R7 grant when idle", coef_wr_grant, 1);
    chk({zs_step, fs_step, sys_src} == 3'b000, "R1 steps after reset", {zs_step, fs_step, sys_src}, 0);

    // Table walk: R2 (01), R3 (10, 11), R8 (00)
    for (int i = 0; i < NVEC; i++) begin
      run_seq(V_MODE[i], V_CAL[i], V_RDY[i], 1'b0, 1'b0,
              (i == 0) ? "R2 vec" : (i == 3) ? "R8 vec" : "R3 vec");
    end
    chk(drdy_n == 1'b0, "R8 drdy_n unchanged by 00", drdy_n, 0);

    // R9: tick coinciding with acceptance is not counted
    run_seq(2'b10, 3, 4, 1'b1, 1'b0, "R9 tick on write");
    run_seq(2'b01, 6, 9, 1'b1, 1'b0, "R9 tick on write self");

    // R6: writes during calibration and during pipeline are ignored
    run_seq(2'b01, 6, 9, 1'b0, 1'b1, "R6 poke self");
    run_seq(2'b11, 3, 4, 1'b0, 1'b1, "R6 poke sys full");

    // R10: pipeline delay bound
    chk(PIPE >= 1 && PIPE <= 2000, "R10 pipeline bound", PIPE, 2000);

    // R1: reset in the middle of a calibration
    @(negedge clk);
    mode_wr = 1'b1; mode_wdata = 2'b01;
    @(negedge clk);
    mode_wr = 1'b0;
    repeat (7) @(negedge clk);
    chk(cal_busy == 1'b1, "R5 busy mid sequence", cal_busy, 1);
    rst_n = 1'b0;
    #1;
    chk(mode_rb == 2'b00, "R1 async readback clear", mode_rb, 0);
    chk(drdy_n == 1'b1, "R1 async drdy_n", drdy_n, 1);
    chk(cal_busy == 1'b0, "R1 async busy clear", cal_busy, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run_seq(2'b10, 3, 4, 1'b0, 1'b0, "R1 after reset sys zero");

    summary();
  end

endmodule